// File: doc/BRIEF.md
# Framed Serial Control Port with Parity and Length Checking

This block is the serial control port of a larger device. A host talks to it over a four-wire, mode-0 serial link: an active-low select, a shift clock, a data input and a data output. The block runs on the device's own clock and oversamples the three link inputs through two-stage synchronisers. Every transaction is a 16-bit word. The host sends it MSB first. The top bits select one of a small set of control registers, the middle bits carry the data, and the lowest bit makes the parity of the whole word odd.

A transaction is checked when the select line goes high again. The word is committed to the addressed register only when exactly 16 shift-clock rising edges arrived and the parity is odd. If either check fails, the registers stay as they were and a sticky error flag is set. The flag is reported in the status word that the next transaction shifts out. That status word is captured when select falls, and it is shifted out MSB first while the host clocks in its command.

After reset the port stays deaf for a parameterised number of clock cycles. This models the startup delay after power-on. The single active-low reset input stands for both the external reset and the internal power-on reset.

Top module: `spi_frame_slave`

## Requirements
- R1: While and after reset, every control register reads zero on `ctrlOut` and `sdoOe` is low.
- R2: For the first READY_CYCLES clock cycles after reset release, select falling is ignored: no register changes and `sdoOe` stays low for that transaction.
- R3: The link runs in mode 0, MSB first. `sdi` is taken on each rising `sclk`. In a received word, bits [15:14] are the register address, bits [13:1] are the data, and bit 0 is the parity bit.
- R4: A word with exactly 16 rising `sclk` edges and an odd number of ones over all 16 bits is written into the addressed register when select rises. Register n appears on `ctrlOut[n*13 +: 13]`.
- R5: A 16-edge word with even parity changes no register. It sets the parity-error flag, which appears as bit 15 of the next status word.
- R6: A transaction with any number of rising edges other than 16 (zero included) changes no register. It sets the frame-error flag (status bit 14) and does not set the parity-error flag.
- R7: The status word is captured at select fall. Its bits are: [15] the parity-error flag, [14] the frame-error flag, [13:1] the contents of the register written by the most recent valid word (register 0 after reset), and [0] a bit that makes the parity of the whole word odd. It is driven MSB first on `sdo`. The first bit is valid before the first rising `sclk`, and each later bit follows a falling `sclk`.
- R8: Both error flags are cleared once a status word carrying them has been captured. A flag is reported only once unless a new error occurs.
- R9: `sdoOe` is low whenever select is high and high during an accepted transaction.
- R10: Asserting reset at any time restores the defaults of R1 and restarts the startup delay of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock that oversamples the link |
| rstN | input | 1 | Active-low asynchronous reset (external and power-on) |
| csN | input | 1 | Active-low transaction select |
| sclk | input | 1 | Shift clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial status data to the host |
| sdoOe | output | 1 | Output enable for `sdo`; the pad is high-impedance when low |
| ctrlOut | output | 52 | All control registers, register n at bits [n*13 +: 13] |

## Verification
Some properties are checked on every cycle. Registers change only in a commit cycle. A finished short or long transaction always raises the frame-error flag, and a full-length word with bad parity always raises the parity-error flag. Both flags are clear right after a status capture. The edge counter never runs past its saturation value. The port is idle while select is high and while the startup delay runs.

Other behaviours need the bench's scenarios. These are the exact bit order and field placement of incoming words, the contents and parity of the shifted-out status word, and the one-transaction delay in error reporting. The bench sweeps every address with several data patterns, every single-bit corruption of a valid word, and every transaction length from 0 to 20 edges. It also covers reset during operation.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  // Per-cycle strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic start;   // accepted select fall: capture status, clear flags
    logic sample;  // rising shift clock inside a transaction
    logic shift;   // falling shift clock inside a transaction
    logic finish;  // select rise closing an accepted transaction
    logic lenOk;   // edge count equals the word length
  } spiStrobes_t;

endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int FRAME_W      = 16,
  parameter int READY_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdiBit,
  output spiStrobes_t st,
  output logic        active
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam int RDY_W = $clog2(READY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_LEN = CNT_W'(FRAME_W);
  localparam logic [RDY_W-1:0] RDY_END = RDY_W'(READY_CYCLES);
  localparam int SYNC_N = 3;
  localparam logic [SYNC_N-1:0] SYNC_RST = 3'b100; // select idles high

  logic [SYNC_N-1:0] rawIn, syncA, syncB;
  logic csS, sclkS, csD, sclkD;
  logic csFall, csRise, sclkRise, sclkFall;
  logic [RDY_W-1:0] readyCnt;
  logic ready;
  logic inFrame;
  logic [CNT_W-1:0] bitCnt;

  assign rawIn = {csN, sclk, sdi};

  // Two-stage synchronisers, one per link input.
  for (genvar g = 0; g < SYNC_N; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= SYNC_RST[g];
        syncB[g] <= SYNC_RST[g];
      end else begin
        syncA[g] <= rawIn[g];
        syncB[g] <= syncA[g];
      end
    end
  end

  assign csS    = syncB[2];
  assign sclkS  = syncB[1];
  assign sdiBit = syncB[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD   <= 1'b1;
      sclkD <= 1'b0;
    end else begin
      csD   <= csS;
      sclkD <= sclkS;
    end
  end

  assign csFall   = csD & ~csS;
  assign csRise   = ~csD & csS;
  assign sclkRise = ~sclkD & sclkS;
  assign sclkFall = sclkD & ~sclkS;

  // Startup delay after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       readyCnt <= '0;
    else if (!ready) readyCnt <= readyCnt + 1'b1;
  end
  assign ready = (readyCnt == RDY_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          inFrame <= 1'b0;
    else if (st.start)  inFrame <= 1'b1;
    else if (st.finish) inFrame <= 1'b0;
  end

  // Saturating rising-edge counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               bitCnt <= '0;
    else if (st.start)                       bitCnt <= '0;
    else if (st.sample && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    st        = '0;
    st.start  = csFall & ready;
    st.sample = inFrame & sclkRise;
    st.shift  = inFrame & sclkFall;
    st.finish = inFrame & csRise;
    st.lenOk  = (bitCnt == CNT_LEN);
  end

  assign active = inFrame;

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !inFrame);

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csD |-> !inFrame);

  // R6
  bitcnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_MAX);

  // R3
  count_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFrame) |-> bitCnt == '0);

endmodule

// File: rtl/spi_frame_dp.sv
module spi_frame_dp
  import spi_frame_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int ADDR_W  = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  spiStrobes_t                            st,
  input  logic                                   sdiBit,
  output logic                                   sdo,
  output logic [(1<<ADDR_W)*(FRAME_W-1-ADDR_W)-1:0] ctrlFlat
);

  localparam int DATA_W   = FRAME_W - 1 - ADDR_W;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int RB_W     = FRAME_W - 3; // readback field, ADDR_W >= 2

  logic [FRAME_W-1:0] rxSh, txSh, statusWord;
  logic [DATA_W-1:0]  regs [NUM_REGS];
  logic [ADDR_W-1:0]  lastAddr, rxAddr;
  logic [DATA_W-1:0]  rxData;
  logic [RB_W-1:0]    rdExt;
  logic perrFlag, ferrFlag, parOk, commit;

  assign rxAddr = rxSh[FRAME_W-1 -: ADDR_W];
  assign rxData = rxSh[DATA_W:1];
  assign parOk  = ^rxSh;
  assign commit = st.finish & st.lenOk & parOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rxSh <= '0;
    else if (st.sample) rxSh <= {rxSh[FRAME_W-2:0], sdiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      lastAddr <= '0;
    end else if (commit) begin
      regs[rxAddr] <= rxData;
      lastAddr     <= rxAddr;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    assign ctrlFlat[g*DATA_W +: DATA_W] = regs[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perrFlag <= 1'b0;
      ferrFlag <= 1'b0;
    end else if (st.start) begin
      perrFlag <= 1'b0;
      ferrFlag <= 1'b0;
    end else if (st.finish) begin
      if (!st.lenOk)  ferrFlag <= 1'b1;
      else if (!parOk) perrFlag <= 1'b1;
    end
  end

  assign rdExt      = RB_W'(regs[lastAddr]);
  assign statusWord = {perrFlag, ferrFlag, rdExt, ~^{perrFlag, ferrFlag, rdExt}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         txSh <= '0;
    else if (st.start) txSh <= statusWord;
    else if (st.shift) txSh <= {txSh[FRAME_W-2:0], 1'b0};
  end

  assign sdo = txSh[FRAME_W-1];

  // R4
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(ctrlFlat));

  // R5
  perr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.finish && st.lenOk && !parOk |=> perrFlag);

  // R6
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.finish && !st.lenOk |=> ferrFlag && $stable(perrFlag));

  // R8
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.start |=> !perrFlag && !ferrFlag);

  // R7
  status_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.start |=> ^txSh);

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_frame_pkg::*;
#(
  parameter int FRAME_W      = 16,
  parameter int ADDR_W       = 2,
  parameter int READY_CYCLES = 1000
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      csN,
  input  logic                                      sclk,
  input  logic                                      sdi,
  output logic                                      sdo,
  output logic                                      sdoOe,
  output logic [(1<<ADDR_W)*(FRAME_W-1-ADDR_W)-1:0] ctrlOut
);

  spiStrobes_t st;
  logic sdiBit;

  spi_frame_ctrl #(.FRAME_W(FRAME_W), .READY_CYCLES(READY_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdiBit(sdiBit), .st(st), .active(sdoOe)
  );

  spi_frame_dp #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .sdiBit(sdiBit),
    .sdo(sdo), .ctrlFlat(ctrlOut)
  );

endmodule

// File: tb/test_spi_frame_slave.sv
module test_spi_frame_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;   // device clocks per shift-clock half period
  localparam int RDY        = 400;
  localparam int DW         = 13;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoOe;
  logic [4*DW-1:0] ctrlOut;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  logic [DW-1:0] expReg [4];
  logic expPerr = 1'b0, expFerr = 1'b0;
  logic [1:0] expLast = 2'd0;

  spi_frame_slave #(.READY_CYCLES(RDY)) i_spi_frame_slave (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .ctrlOut(ctrlOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(input logic [1:0] a, input logic [DW-1:0] d);
    return {a, d, ~^{a, d}};
  endfunction

  function automatic logic [15:0] expStatus();
    return {expPerr, expFerr, expReg[expLast], ~^{expPerr, expFerr, expReg[expLast]}};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nBits clocks; the first 16 carry word MSB first, extras send 0.
  task automatic xfer(input int nBits, input logic [15:0] word,
                      output logic [15:0] rx, output logic oeSeen);
    rx = '0;
    @(negedge clk);
    csN = 1'b0;
    waitClk(8);
    oeSeen = sdoOe;
    for (int b = 0; b < nBits; b++) begin
      sdi = (b < 16) ? word[15-b] : 1'b0;
      waitClk(HALF);
      if (b < 16) rx[15-b] = sdo;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    sdi = 1'b0;
    waitClk(8);
  endtask

  // Full transaction with model update; checks status and enable.
  task automatic frame(input int nBits, input logic [15:0] word, input string req);
    logic [15:0] rx, expSt;
    logic oe;
    bit lenOk, parOk;
    expSt = expStatus();
    xfer(nBits, word, rx, oe);
    check(oe === 1'b1, "R9", "sdoOe during transaction", 64'(oe), 64'd1);
    if (nBits >= 16)
      check(rx === expSt, "R7", "status word on sdo", 64'(rx), 64'(expSt));
    expPerr = 1'b0;
    expFerr = 1'b0;
    lenOk = (nBits == 16);
    parOk = ^word;
    if (!lenOk) expFerr = 1'b1;
    else if (!parOk) expPerr = 1'b1;
    else begin
      expReg[word[15:14]] = word[13:1];
      expLast = word[15:14];
    end
    for (int a = 0; a < 4; a++)
      check(ctrlOut[a*DW +: DW] === expReg[a], req, "register contents",
            64'(ctrlOut[a*DW +: DW]), 64'(expReg[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx, st;
    logic oe;
    for (int a = 0; a < 4; a++) expReg[a] = '0;

    // R1: defaults during and after reset
    waitClk(3);
    check(ctrlOut === '0, "R1", "ctrlOut in reset", 64'(ctrlOut), 64'd0);
    check(sdoOe === 1'b0, "R1", "sdoOe in reset", 64'(sdoOe), 64'd0);
    rstN = 1'b1;
    waitClk(1);
    check(ctrlOut === '0, "R1", "ctrlOut after reset", 64'(ctrlOut), 64'd0);

    // R2: transaction inside the startup delay is ignored
    xfer(16, mkWord(2'd1, 13'h1234), rx, oe);
    check(oe === 1'b0, "R2", "sdoOe before ready", 64'(oe), 64'd0);
    check(ctrlOut === '0, "R2", "no write before ready", 64'(ctrlOut), 64'd0);
    waitClk(RDY);
    check(sdoOe === 1'b0, "R9", "sdoOe with select high", 64'(sdoOe), 64'd0);

    // R3, R4: every address with several data patterns
    for (int a = 0; a < 4; a++) begin
      frame(16, mkWord(2'(a), 13'h1555), "R4");
      frame(16, mkWord(2'(a), 13'h0AAA), "R3");
      frame(16, mkWord(2'(a), 13'(a * 'h123 + 1)), "R4");
    end

    // R5: every single-bit corruption of a valid word
    for (int i = 0; i < 16; i++) begin
      frame(16, mkWord(2'd1, 13'h0F0F) ^ (16'd1 << i), "R5");
      frame(16, mkWord(2'd3, 13'(i * 7)), "R5");
    end

    // R6: all lengths from 0 to 20 except 16
    for (int n = 0; n <= 20; n++) begin
      if (n == 16) continue;
      frame(n, mkWord(2'd2, 13'h1F00 | 13'(n)), "R6");
    end

    // R8: error reported once, then cleared
    frame(3, mkWord(2'd0, 13'h0001), "R6");
    st = expStatus();
    check(st[15:14] == 2'b01, "R6", "model flags after short frame", 64'(st[15:14]), 64'd1);
    frame(16, mkWord(2'd0, 13'h0042), "R8");
    expPerr = 1'b0; expFerr = 1'b0;
    xfer(16, mkWord(2'd0, 13'h0043), rx, oe);
    check(rx[15:14] === 2'b00, "R8", "flags cleared after report", 64'(rx[15:14]), 64'd0);
    expReg[0] = 13'h0043;
    expLast = 2'd0;

    // R10: reset during operation
    @(negedge clk);
    rstN = 1'b0;
    waitClk(2);
    rstN = 1'b1;
    waitClk(1);
    check(ctrlOut === '0, "R10", "registers after late reset", 64'(ctrlOut), 64'd0);
    xfer(16, mkWord(2'd2, 13'h0777), rx, oe);
    check(oe === 1'b0, "R10", "startup delay restarted", 64'(oe), 64'd0);
    check(ctrlOut === '0, "R10", "no write during restart delay", 64'(ctrlOut), 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule